// File: doc/BRIEF.md
# Halfband Polyphase Interpolator by Two

This block doubles the sample rate of a signed stream with a fifth-order elliptic halfband response, built from two first-order allpass branches. Each accepted input sample goes to both branches. Each branch keeps its delay state at the input rate. The outputs of the two branches are interleaved, so every input produces two output samples on consecutive cycles. The stream is never zero-stuffed, and no branch does any work for the inserted zeros.

Coefficients are restricted to short sums of powers of two, and one of three fixed sets is chosen by a parameter. Each coefficient product is therefore a handful of arithmetic shifts and adds. A single shift-add datapath serves both branches and is steered by a phase bit. The upstream side uses a valid/ready handshake. The downstream side sees one valid strobe per output sample, with no backpressure.

Top module: `hbi_interp`

## Requirements
- R1: While reset is asserted, and after reset is released until the first input is accepted, `out_valid` is 0 and `in_ready` is 1. All branch delay state starts at zero, so the first outputs are those of a filter with empty history.
- R2: A sample is taken when `in_valid` and `in_ready` are both 1 at a rising clock edge. `in_ready` is 0 for exactly the one cycle after each acceptance, and is 1 otherwise.
- R3: Each accepted sample causes exactly two `out_valid` cycles. The branch 0 result is presented in the cycle after the accepting edge, and the branch 1 result in the cycle after that. `out_valid` is 0 in every other cycle.
- R4: The accepted sample is scaled by 2^FRAC and sign-extended to an internal word of IN_W+FRAC+GUARD bits. All internal arithmetic wraps in two's complement at that width.
- R5: Each branch b computes y = c_b·(x − y_prev) + x_prev. Here x_prev and y_prev are that branch's input and output for the previous accepted sample. A branch's state changes only in its own output slot.
- R6: Each coefficient product is the signed sum of the difference arithmetically shifted right (floor) by each term's amount. The terms for each COEF_SET are:
  - COEF_SET 0: branch 0 uses >>3; branch 1 uses >>1 and >>4.
  - COEF_SET 1: branch 0 uses >>3 and >>4; branch 1 uses >>1, >>3 and >>5.
  - COEF_SET 2: branch 0 uses >>2 and −(>>5); branch 1 uses >>1, >>3, >>4 and >>7.
- R7: Each output is the internal value plus 2^(FRAC−1), arithmetically shifted right by FRAC. This rounds half toward positive infinity.
- R8: A rounded value above 2^(IN_W−1)−1 or below −2^(IN_W−1) is clamped to that limit.
- R9: `in_data` offered while `in_ready` is 0 is not consumed. The branch 1 output still uses the held sample, and that offered value affects no later output.
- R10: A constant input held for long enough settles to an output equal to the input within one LSB, for both branch slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the output rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_data | output | IN_W | Signed interleaved output sample |

## Verification
The checker assumes the clock runs at the output rate and that any upstream source respects `in_ready`. It also assumes the downstream side never needs to stall, because the block has no output backpressure. The handshake properties only relate `in_valid`, `in_ready` and `out_valid`, so they hold for any input pattern. The bench drives `in_valid` randomly, keeps it high through stall cycles to exercise the ignore rule, and uses full-scale swings to reach the clamping limits.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  localparam int TERMS = 4;

  // sgn: 0 = unused term, 1 = add, 2 = subtract
  typedef struct packed {
    logic [1:0] sgn;
    logic [3:0] sh;
  } term_t;

  function automatic term_t coef_term(input int set, input int br, input int idx);
    term_t t;
    t = '{sgn: 2'd0, sh: 4'd0};
    case (set * 100 + br * 10 + idx)
      0:   t = '{sgn: 2'd1, sh: 4'd3};
      10:  t = '{sgn: 2'd1, sh: 4'd1};
      11:  t = '{sgn: 2'd1, sh: 4'd4};
      100: t = '{sgn: 2'd1, sh: 4'd3};
      101: t = '{sgn: 2'd1, sh: 4'd4};
      110: t = '{sgn: 2'd1, sh: 4'd1};
      111: t = '{sgn: 2'd1, sh: 4'd3};
      112: t = '{sgn: 2'd1, sh: 4'd5};
      200: t = '{sgn: 2'd1, sh: 4'd2};
      201: t = '{sgn: 2'd2, sh: 4'd5};
      210: t = '{sgn: 2'd1, sh: 4'd1};
      211: t = '{sgn: 2'd1, sh: 4'd3};
      212: t = '{sgn: 2'd1, sh: 4'd4};
      213: t = '{sgn: 2'd1, sh: 4'd7};
      default: t = '{sgn: 2'd0, sh: 4'd0};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/hbi_shift_add.sv
module hbi_shift_add #(
  parameter int W        = 21,
  parameter int COEF_SET = 0
) (
  input  logic                sel,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] p
);

  localparam int TERMS = hbi_pkg::TERMS;

  logic signed [W-1:0] term_v [TERMS];

  for (genvar g = 0; g < TERMS; g++) begin : g_term
    localparam hbi_pkg::term_t T0 = hbi_pkg::coef_term(COEF_SET, 0, g);
    localparam hbi_pkg::term_t T1 = hbi_pkg::coef_term(COEF_SET, 1, g);
    hbi_pkg::term_t      t;
    logic signed [W-1:0] shd;
    assign t   = sel ? T1 : T0;
    assign shd = d >>> t.sh;
    assign term_v[g] = (t.sgn == 2'd1) ? shd :
                       (t.sgn == 2'd2) ? -shd : '0;
  end

  always_comb begin
    p = '0;
    for (int i = 0; i < TERMS; i++) p = p + term_v[i];
  end

endmodule

// File: rtl/hbi_branch_state.sv
module hbi_branch_state #(
  parameter int W = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  output logic signed [W-1:0] x_dly,
  output logic signed [W-1:0] y_dly
);

  logic signed [W-1:0] x_d, y_d;

  always_comb begin
    x_d = x_dly;
    y_d = y_dly;
    if (en) begin
      x_d = x_in;
      y_d = y_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_dly <= '0;
      y_dly <= '0;
    end else begin
      x_dly <= x_d;
      y_dly <= y_d;
    end
  end

endmodule

// File: rtl/hbi_round_sat.sv
module hbi_round_sat #(
  parameter int W     = 21,
  parameter int FRAC  = 3,
  parameter int OUT_W = 16
) (
  input  logic signed [W-1:0]     v,
  output logic signed [OUT_W-1:0] q
);

  localparam int RW = W + 1;
  localparam logic signed [RW-1:0] BIAS = RW'(2 ** (FRAC - 1));
  localparam logic signed [RW-1:0] MAXV = RW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [RW-1:0] MINV = -MAXV - RW'(1);

  logic signed [RW-1:0] biased, shifted;

  always_comb begin
    biased  = $signed({v[W-1], v}) + BIAS;
    shifted = biased >>> FRAC;
    if (shifted > MAXV)      q = MAXV[OUT_W-1:0];
    else if (shifted < MINV) q = MINV[OUT_W-1:0];
    else                     q = shifted[OUT_W-1:0];
  end

endmodule

// File: rtl/hbi_interp.sv
module hbi_interp #(
  parameter int IN_W     = 16,
  parameter int FRAC     = 3,
  parameter int GUARD    = 2,
  parameter int COEF_SET = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   out_valid,
  output logic signed [IN_W-1:0] out_data
);

  localparam int W        = IN_W + FRAC + GUARD;
  localparam int BRANCHES = 2;

  // phase_q = 0: idle / branch 0 slot on acceptance; 1: branch 1 slot
  logic                   phase_q, phase_d;
  logic signed [W-1:0]    xh_q, xh_d;
  logic                   ov_d;
  logic signed [IN_W-1:0] od_d;

  logic                   accept;
  logic signed [W-1:0]    x_new, x_cur, xd_sel, yd_sel, diff, prod, y_cur;
  logic signed [IN_W-1:0] y_rs;
  logic [BRANCHES-1:0]    br_en;
  logic signed [W-1:0]    xd_q [BRANCHES];
  logic signed [W-1:0]    yd_q [BRANCHES];

  assign in_ready = ~phase_q;
  assign accept   = in_valid & ~phase_q;
  assign x_new    = $signed({{GUARD{in_data[IN_W-1]}}, in_data, {FRAC{1'b0}}});

  // shared datapath operands, steered by phase
  assign x_cur  = phase_q ? xh_q     : x_new;
  assign xd_sel = phase_q ? xd_q[1]  : xd_q[0];
  assign yd_sel = phase_q ? yd_q[1]  : yd_q[0];
  assign diff   = x_cur - yd_sel;
  assign y_cur  = prod + xd_sel;
  assign br_en  = {phase_q, accept};

  hbi_shift_add #(.W(W), .COEF_SET(COEF_SET)) u_mul (
    .sel (phase_q),
    .d   (diff),
    .p   (prod)
  );

  for (genvar b = 0; b < BRANCHES; b++) begin : g_br
    hbi_branch_state #(.W(W)) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (br_en[b]),
      .x_in  (x_cur),
      .y_in  (y_cur),
      .x_dly (xd_q[b]),
      .y_dly (yd_q[b])
    );
  end

  hbi_round_sat #(.W(W), .FRAC(FRAC), .OUT_W(IN_W)) u_rs (
    .v (y_cur),
    .q (y_rs)
  );

  always_comb begin
    phase_d = phase_q;
    xh_d    = xh_q;
    ov_d    = 1'b0;
    od_d    = out_data;
    if (phase_q) begin
      phase_d = 1'b0;
      ov_d    = 1'b1;
      od_d    = y_rs;
    end else if (accept) begin
      phase_d = 1'b1;
      xh_d    = x_new;
      ov_d    = 1'b1;
      od_d    = y_rs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      xh_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      phase_q   <= phase_d;
      xh_q      <= xh_d;
      out_valid <= ov_d;
      out_data  <= od_d;
    end
  end

endmodule

// File: rtl/hbi_interp_chk.sv
module hbi_interp_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid
);

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready); // R2

  AST_PAIR_EMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !in_ready) ##1 out_valid); // R3

  AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!in_ready || $past(!in_ready))); // R3

  AST_STALL_MEANS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid); // R3

endmodule

bind hbi_interp hbi_interp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid)
);

// File: tb/hbi_interp_bench.sv
module hbi_interp_bench;

  localparam int IN_W  = 16;
  localparam int FRAC  = 3;
  localparam int GUARD = 2;
  localparam int W     = IN_W + FRAC + GUARD;
  localparam int NSET  = 3;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic                   rdy   [NSET];
  logic                   ovld  [NSET];
  logic signed [IN_W-1:0] odat  [NSET];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  hbi_interp #(.IN_W(IN_W), .FRAC(FRAC), .GUARD(GUARD), .COEF_SET(0)) u_hbi_interp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]),
    .in_data(in_data), .out_valid(ovld[0]), .out_data(odat[0]));
  hbi_interp #(.IN_W(IN_W), .FRAC(FRAC), .GUARD(GUARD), .COEF_SET(1)) u_hbi_interp_s1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]),
    .in_data(in_data), .out_valid(ovld[1]), .out_data(odat[1]));
  hbi_interp #(.IN_W(IN_W), .FRAC(FRAC), .GUARD(GUARD), .COEF_SET(2)) u_hbi_interp_s2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[2]),
    .in_data(in_data), .out_valid(ovld[2]), .out_data(odat[2]));

  // reference model state
  longint xd [NSET][2];
  longint yd [NSET][2];
  longint xh;
  bit     phase;
  bit     exp_v;
  longint exp_d [NSET];

  function automatic longint wrapw(input longint v);
    longint m;
    m = v & ((64'sd1 <<< W) - 1);
    if (m >= (64'sd1 <<< (W - 1))) m = m - (64'sd1 <<< W);
    return m;
  endfunction

  // R6 coefficient products from the requirement's term lists
  function automatic longint coef_mul(input int s, input int b, input longint d);
    case (s * 10 + b)
      0:  return d >>> 3;
      1:  return (d >>> 1) + (d >>> 4);
      10: return (d >>> 3) + (d >>> 4);
      11: return (d >>> 1) + (d >>> 3) + (d >>> 5);
      20: return (d >>> 2) - (d >>> 5);
      default: return (d >>> 1) + (d >>> 3) + (d >>> 4) + (d >>> 7);
    endcase
  endfunction

  // R7 rounding and R8 clamping
  function automatic longint round_sat(input longint v);
    longint r;
    r = (v + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    if (r > (64'sd1 <<< (IN_W - 1)) - 1) r = (64'sd1 <<< (IN_W - 1)) - 1;
    if (r < -(64'sd1 <<< (IN_W - 1)))    r = -(64'sd1 <<< (IN_W - 1));
    return r;
  endfunction

  function automatic longint step(input int s, input int b, input longint x);
    longint d, p, y;
    d = wrapw(x - yd[s][b]);
    p = wrapw(coef_mul(s, b, d));
    y = wrapw(p + xd[s][b]);
    xd[s][b] = x;
    yd[s][b] = y;
    return y;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // drive one cycle (called just after a falling edge), then check after the next falling edge
  task automatic cycle(input bit v, input longint dat);
    for (int s = 0; s < NSET; s++) check(rdy[s] == !phase, "R2 ready", rdy[s], !phase);
    in_valid = v;
    in_data  = dat[IN_W-1:0];
    if (!phase && v) begin
      xh = wrapw(longint'(in_data) <<< FRAC);   // R4
      for (int s = 0; s < NSET; s++) exp_d[s] = round_sat(step(s, 0, xh));
      exp_v = 1'b1;
      phase = 1'b1;
    end else if (phase) begin
      for (int s = 0; s < NSET; s++) exp_d[s] = round_sat(step(s, 1, xh));
      exp_v = 1'b1;
      phase = 1'b0;
    end else begin
      exp_v = 1'b0;
    end
    @(negedge clk);
    for (int s = 0; s < NSET; s++) begin
      check(ovld[s] == exp_v, "R3 out_valid", ovld[s], exp_v);
      if (exp_v) check(longint'(odat[s]) == exp_d[s], tag, odat[s], exp_d[s]);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    longint r;
    void'($urandom(32'h5EED_0042));
    for (int s = 0; s < NSET; s++)
      for (int b = 0; b < 2; b++) begin xd[s][b] = 0; yd[s][b] = 0; end
    phase = 1'b0;
    xh = 0;

    // R1: reset values
    repeat (3) @(negedge clk);
    for (int s = 0; s < NSET; s++) begin
      check(ovld[s] == 1'b0, "R1 out_valid in reset", ovld[s], 0);
      check(rdy[s] == 1'b1, "R1 in_ready in reset", rdy[s], 1);
      check(odat[s] == '0, "R1 out_data in reset", odat[s], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cycle(1'b0, 0);
    for (int s = 0; s < NSET; s++) check(ovld[s] == 1'b0, "R1 idle after reset", ovld[s], 0);

    // R1/R5: first pair from empty history, impulse response
    tag = "R1 R5 first outputs";
    cycle(1'b1, 16000);
    cycle(1'b0, 0);
    tag = "R5 R6 impulse tail";
    for (int i = 0; i < 20; i++) begin cycle(1'b1, 0); cycle(1'b0, 0); end

    // R9: change data while stalled
    tag = "R9 stalled data ignored";
    for (int i = 0; i < 40; i++) begin
      cycle(1'b1, 1000 + i);
      cycle(1'b1, -30000);
    end

    // R8: full-scale alternation drives overshoot into clamping
    tag = "R8 R7 full swing";
    for (int i = 0; i < 60; i++) begin
      cycle(1'b1, (i % 2) ? -32768 : 32767);
      cycle(1'b1, 0);
    end
    for (int i = 0; i < 30; i++) begin
      cycle(1'b1, (i % 4 < 2) ? 32767 : -32768);
      cycle(1'b0, 0);
    end

    // R10: constant input settles to unity gain
    tag = "R10 R4 constant input";
    for (int i = 0; i < 300; i++) begin cycle(1'b1, -1234); cycle(1'b0, 0); end
    for (int i = 0; i < 4; i++) begin
      cycle(1'b1, -1234);
      for (int s = 0; s < NSET; s++)
        check(odat[s] >= -1235 && odat[s] <= -1233, "R10 settled branch0", odat[s], -1234);
      cycle(1'b1, -1234);
      for (int s = 0; s < NSET; s++)
        check(odat[s] >= -1235 && odat[s] <= -1233, "R10 settled branch1", odat[s], -1234);
    end

    // random stimulus, random gaps
    tag = "R5 R6 R7 random";
    for (int i = 0; i < 3000; i++) begin
      r = longint'($signed(16'($urandom())));
      if ($urandom_range(9) == 0) r = ($urandom_range(1) != 0) ? 32767 : -32768;
      cycle($urandom_range(9) < 7, r);
    end

    cycle(1'b0, 0);
    cycle(1'b0, 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule